// File: doc/BRIEF.md
# Programmable-Tap Convolutional Encoder

This block is a rate-1/N convolutional encoder. Its generator polynomials sit in a small writable table instead of being fixed in logic. A radio that moves between standards rewrites only that table and keeps the same encoder. A burst opens with a start pulse. Every accepted data bit then yields N coded bits, which leave one per enabled cycle on a single-bit serial output. An optional tail of K-1 zero bits can follow the last data bit, so that the trellis ends in the all-zero state.

The shift register has K-1 stages of memory, and there is one modulo-2 adder per polynomial. For each polynomial, bit K-1 taps the bit being encoded and bit 0 taps the oldest stored bit. A clock-enable input gates every internal step. A clear input drops an unfinished burst at once, so the block can follow an external task start/finish semaphore. Table writes are accepted only while the encoder is idle. The table is copied into the working tap set at each start.

Top module: `prog_conv_encoder`

## Requirements
- R1: After reset the encoder is idle: `busy`, `done`, `inReady` and `outValid` are low.
- R2: Coded bit j for an input bit is the XOR over i of `poly[j][i] & w[i]`. Here w[K-1] is the current input bit and w[K-2] down to w[0] are the previous bits, from most recent to oldest. Only the low K bits of each 16-bit table word are used.
- R3: Each accepted input bit produces exactly N output bits, coded bit 0 first, one bit per cycle with `clkEn` high. The next input bit is accepted only once all N bits have left.
- R4: A start pulse in idle clears the shift register and raises `busy`. The output of a burst therefore does not depend on earlier bursts.
- R5: A table write (`cfgWe`, index `cfgSel`, value `cfgData`) made in idle takes effect at the next start.
- R6: A table write made while `busy` is high is discarded.
- R7: If `flushEn` is high at start, K-1 zero bits are encoded after the bit marked `inLast`, which gives 2·(K-1) extra output bits for N=2.
- R8: If `flushEn` is low at start, the burst ends after the N output bits of the bit marked `inLast`.
- R9: When a burst ends, `done` is high for exactly one cycle, `busy` is low in that same cycle, and no output bit follows.
- R10: While `clkEn` is low, no input bit is accepted, no output bit is emitted and no state advances. The coded sequence is the same as without stalls.
- R11: `ceClr` returns the encoder to idle on the next edge. Pending output bits are discarded and `done` is not raised.
- R12: The reset contents of the table are 0o171 for polynomial 0 and 0o133 for polynomial 1, with K = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Polynomial table write strobe |
| cfgSel | input | SEL_W | Table index to write |
| cfgData | input | PW | Polynomial value, LSB taps the oldest bit |
| start | input | 1 | Begin a burst (idle only) |
| flushEn | input | 1 | Append K-1 zero tail bits in this burst |
| clkEn | input | 1 | Clock enable for all stepping |
| ceClr | input | 1 | Abort the burst and return to idle |
| inValid | input | 1 | Input bit present |
| inBit | input | 1 | Data bit |
| inLast | input | 1 | Marks the last data bit of the burst |
| inReady | output | 1 | Encoder takes the input bit this cycle |
| outValid | output | 1 | Coded bit present this cycle |
| outBit | output | 1 | Coded bit |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
An impulse-like pattern and a run of ones are compared against an independent model with the reset polynomials. A swapped tap order or a wrong window position would show up as a mismatch against that model. A burst with a tail is counted bit by bit, so a tail one bit short or one bit long is caught. It also starts right after a burst that left ones in the register, which exposes a shift register that is not cleared at start. Table writes are tried both in idle and in mid-burst: a design that takes the late write changes the coded sequence of the current burst or of the next one. A stalled burst and an aborted burst check that a low enable freezes the serialiser and that an abort suppresses both the pending bits and the `done` pulse.

// File: rtl/pce_pkg.sv
package pce_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_TAIL,
    ST_DRAIN
  } encState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clearSr;   // zero the history at burst start
    logic loadPoly;  // copy the table into the working taps
    logic step;      // encode stepBit this cycle
    logic stepBit;   // bit to encode (data or tail zero)
    logic abort;     // drop pending output bits
    logic tableWr;   // table write allowed this cycle
  } encCtl_t;

endpackage

// File: rtl/pce_ctrl.sv
module pce_ctrl
  import pce_pkg::*;
#(
  parameter int K = 7
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    flushEn,
  input  logic    clkEn,
  input  logic    ceClr,
  input  logic    inValid,
  input  logic    inBit,
  input  logic    inLast,
  input  logic    cfgWe,
  input  logic    serEmpty,
  output encCtl_t ctl,
  output logic    inReady,
  output logic    busy,
  output logic    done
);

  localparam int TW = $clog2(K);

  encState_t      state;
  logic [TW-1:0]  tailCnt;
  logic           flushReg;
  logic           doneQ;

  always_comb begin
    ctl         = '0;
    inReady     = 1'b0;
    ctl.tableWr = cfgWe && (state == ST_IDLE);
    if (ceClr) begin
      ctl.abort = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            ctl.clearSr  = 1'b1;
            ctl.loadPoly = 1'b1;
          end
        end
        ST_RUN: begin
          inReady = serEmpty && clkEn;
          if (inReady && inValid) begin
            ctl.step    = 1'b1;
            ctl.stepBit = inBit;
          end
        end
        ST_TAIL: begin
          if (serEmpty && clkEn) begin
            ctl.step    = 1'b1;
            ctl.stepBit = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tailCnt  <= '0;
      flushReg <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (ceClr) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (start) begin
              state    <= ST_RUN;
              flushReg <= flushEn;
            end
          end
          ST_RUN: begin
            if (ctl.step && inLast) begin
              if (flushReg) begin
                state   <= ST_TAIL;
                tailCnt <= TW'(K - 1);
              end else begin
                state <= ST_DRAIN;
              end
            end
          end
          ST_TAIL: begin
            if (ctl.step) begin
              tailCnt <= tailCnt - 1'b1;
              if (tailCnt == TW'(1)) state <= ST_DRAIN;
            end
          end
          ST_DRAIN: begin
            if (serEmpty) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  // R9: end-of-burst pulse lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: encoder already idle when the pulse is seen
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R11: clear input forces idle on the next edge
  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    ceClr |=> !busy && !done);

endmodule

// File: rtl/pce_datapath.sv
module pce_datapath
  import pce_pkg::*;
#(
  parameter int             K         = 7,
  parameter int             N         = 2,
  parameter int             PW        = 16,
  parameter int             SEL_W     = 1,
  parameter logic [N*PW-1:0] DEF_POLYS = {16'h005B, 16'h0079}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  encCtl_t          ctl,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic [PW-1:0]    cfgData,
  output logic             serEmpty,
  output logic             outValid,
  output logic             outBit
);

  localparam int CW = $clog2(N + 1);

  logic [N-1:0][PW-1:0] polyTable;
  logic [N-1:0][K-1:0]  activePoly;
  logic [K-2:0]         histReg;
  logic [K-1:0]         window;
  logic [N-1:0]         coded;
  logic [N-1:0]         outWord;
  logic [CW-1:0]        outCnt;

  assign window = {ctl.stepBit, histReg};

  for (genvar j = 0; j < N; j++) begin : g_adder
    assign coded[j] = ^(activePoly[j] & window);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polyTable <= DEF_POLYS;
    end else if (ctl.tableWr) begin
      for (int j = 0; j < N; j++) begin
        if (cfgSel == SEL_W'(j)) polyTable[j] <= cfgData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < N; j++) activePoly[j] <= DEF_POLYS[j*PW +: K];
    end else if (ctl.loadPoly) begin
      for (int j = 0; j < N; j++) activePoly[j] <= polyTable[j][K-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histReg <= '0;
    end else if (ctl.clearSr) begin
      histReg <= '0;
    end else if (ctl.step) begin
      histReg <= window[K-1:1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord <= '0;
      outCnt  <= '0;
    end else if (ctl.abort) begin
      outCnt <= '0;
    end else if (ctl.step) begin
      outWord <= coded;
      outCnt  <= CW'(N);
    end else if (outCnt != '0 && clkEn) begin
      outWord <= outWord >> 1;
      outCnt  <= outCnt - 1'b1;
    end
  end

  assign serEmpty = (outCnt == '0);
  assign outValid = !serEmpty && clkEn;
  assign outBit   = outWord[0];

  // R3: a new bit is encoded only into an empty serialiser
  a_r3_step_empty: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> serEmpty);

  // R3: never more than N bits pending
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= CW'(N));

  // R10: a low enable freezes the serialiser
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !ctl.abort && !serEmpty) |=> $stable(outCnt) && $stable(outWord));

endmodule

// File: rtl/prog_conv_encoder.sv
module prog_conv_encoder
  import pce_pkg::*;
#(
  parameter int             K         = 7,
  parameter int             N         = 2,
  parameter int             PW        = 16,
  parameter logic [N*PW-1:0] DEF_POLYS = {16'h005B, 16'h0079},
  localparam int            SEL_W     = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic [PW-1:0]    cfgData,
  input  logic             start,
  input  logic             flushEn,
  input  logic             clkEn,
  input  logic             ceClr,
  input  logic             inValid,
  input  logic             inBit,
  input  logic             inLast,
  output logic             inReady,
  output logic             outValid,
  output logic             outBit,
  output logic             busy,
  output logic             done
);

  encCtl_t ctl;
  logic    serEmpty;

  pce_ctrl #(.K(K)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .flushEn (flushEn),
    .clkEn   (clkEn),
    .ceClr   (ceClr),
    .inValid (inValid),
    .inBit   (inBit),
    .inLast  (inLast),
    .cfgWe   (cfgWe),
    .serEmpty(serEmpty),
    .ctl     (ctl),
    .inReady (inReady),
    .busy    (busy),
    .done    (done)
  );

  pce_datapath #(
    .K(K), .N(N), .PW(PW), .SEL_W(SEL_W), .DEF_POLYS(DEF_POLYS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .clkEn   (clkEn),
    .ctl     (ctl),
    .cfgSel  (cfgSel),
    .cfgData (cfgData),
    .serEmpty(serEmpty),
    .outValid(outValid),
    .outBit  (outBit)
  );

  // R6: the table cannot change in a cycle that follows a busy cycle
  a_r6_no_write_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(u_dp.polyTable));

endmodule

// File: tb/tb_prog_conv_encoder.sv
module tb_prog_conv_encoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [0:0]  cfgSel = '0;
  logic [15:0] cfgData = '0;
  logic        start = 1'b0;
  logic        flushEn = 1'b0;
  logic        clkEn;
  logic        ceClr = 1'b0;
  logic        inValid = 1'b0;
  logic        inBit = 1'b0;
  logic        inLast = 1'b0;
  logic        inReady, outValid, outBit, busy, done;

  int errors = 0;
  int checks = 0;

  prog_conv_encoder dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .start(start), .flushEn(flushEn), .clkEn(clkEn), .ceClr(ceClr),
    .inValid(inValid), .inBit(inBit), .inLast(inLast), .inReady(inReady),
    .outValid(outValid), .outBit(outBit), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  // enable pattern: steady high, or low one cycle in three when stalling
  logic stallOn = 1'b0;
  int   stallPh = 0;
  always @(negedge clk) begin
    stallPh = (stallPh + 1) % 3;
    clkEn   = stallOn ? (stallPh != 0) : 1'b1;
  end

  // monitor, sampled one ns after the falling edge
  logic gotV [256];
  int   gotN = 0;
  int   doneCnt = 0;
  int   gotAtDone = 0;
  int   readyWhileOff = 0;
  always begin
    @(negedge clk);
    #1;
    if (rstN) begin
      if (outValid && gotN < 256) begin
        gotV[gotN] = outBit;
        gotN++;
      end
      if (done) begin
        doneCnt++;
        gotAtDone = gotN;
      end
      if (!clkEn && (inReady || outValid)) readyWhileOff++;
    end
  end

  // reference model
  logic       dataV [64];
  logic       expV [256];
  int         expN;
  logic [6:0] pol0 = 7'o171;
  logic [6:0] pol1 = 7'o133;

  task automatic buildModel(input int nData, input logic withTail);
    logic [5:0] hist;
    logic [6:0] w;
    int total;
    hist  = '0;
    expN  = 0;
    total = nData + (withTail ? 6 : 0);
    for (int i = 0; i < total; i++) begin
      w = {(i < nData) ? dataV[i] : 1'b0, hist};
      expV[expN]     = ^(w & pol0);
      expV[expN + 1] = ^(w & pol1);
      expN += 2;
      hist = w[6:1];
    end
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [15:0] val);
    cfgWe = 1'b1; cfgSel = sel; cfgData = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sendBit(input logic b, input logic last);
    inValid = 1'b1; inBit = b; inLast = last;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic beginBurst(input logic withTail);
    gotN = 0;
    flushEn = withTail;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finishBurst(input string req);
    int d0;
    int mism;
    d0 = doneCnt;
    for (int c = 0; c < 400 && doneCnt == d0; c++) @(negedge clk);
    @(negedge clk);
    check(doneCnt == d0 + 1, {req, " done pulse count"}, doneCnt - d0, 1);
    check(gotAtDone == expN, {req, " bits before done"}, gotAtDone, expN);
    check(gotN == expN, {req, " output bit count"}, gotN, expN);
    mism = 0;
    for (int i = 0; i < expN && i < gotN; i++) if (gotV[i] !== expV[i]) mism++;
    check(mism == 0, {req, " coded sequence mismatches"}, mism, 0);
    check(!busy, {req, " idle after burst"}, busy, 0);
  endtask

  task automatic runData(input int n, input logic withTail, input string req);
    beginBurst(withTail);
    for (int i = 0; i < n; i++) sendBit(dataV[i], i == n - 1);
    buildModel(n, withTail);
    finishBurst(req);
  endtask

  // R1: reset state
  task automatic t_reset();
    check(!busy, "R1 busy", busy, 0);
    check(!done, "R1 done", done, 0);
    check(!inReady, "R1 inReady", inReady, 0);
    check(!outValid, "R1 outValid", outValid, 0);
  endtask

  // R12, R2, R3, R8: impulse then ones with reset taps, no tail
  task automatic t_defaults();
    for (int i = 0; i < 14; i++) dataV[i] = (i == 0) || (i >= 10);
    runData(14, 1'b0, "R12_R2_R3_R8 default taps");
  endtask

  // R7, R4: tail after a burst that left ones in the history
  task automatic t_tail();
    for (int i = 0; i < 5; i++) dataV[i] = (i % 2 == 0);
    runData(5, 1'b1, "R7_R4 flush tail");
    check(expN == 22, "R7 tail length", expN, 22);
  endtask

  // R5: idle write used from next start
  task automatic t_newTaps();
    cfgWrite(1'b0, 16'h004F);
    cfgWrite(1'b1, 16'hFF65);
    pol0 = 7'h4F;
    pol1 = 7'h65;
    for (int i = 0; i < 9; i++) dataV[i] = (i == 0) || (i == 3) || (i == 4);
    runData(9, 1'b1, "R5 rewritten taps");
  endtask

  // R6: mid-burst write discarded now and later
  task automatic t_busyWrite();
    for (int i = 0; i < 6; i++) dataV[i] = (i != 2);
    beginBurst(1'b0);
    sendBit(dataV[0], 1'b0);
    cfgWrite(1'b0, 16'h0079);
    cfgWrite(1'b1, 16'h005B);
    for (int i = 1; i < 6; i++) sendBit(dataV[i], i == 5);
    buildModel(6, 1'b0);
    finishBurst("R6 busy write this burst");
    runData(6, 1'b0, "R6 busy write next burst");
  endtask

  // R10: periodic stalls leave the coded stream unchanged
  task automatic t_stall();
    for (int i = 0; i < 8; i++) dataV[i] = (i % 3 == 1);
    readyWhileOff = 0;
    stallOn = 1'b1;
    runData(8, 1'b1, "R10 stalled burst");
    stallOn = 1'b0;
    check(readyWhileOff == 0, "R10 activity with enable low", readyWhileOff, 0);
  endtask

  // R11: abort discards pending bits and raises no done
  task automatic t_abort();
    int d0;
    int g0;
    d0 = doneCnt;
    beginBurst(1'b1);
    sendBit(1'b1, 1'b0);
    sendBit(1'b1, 1'b0);
    ceClr = 1'b1;
    @(negedge clk);
    ceClr = 1'b0;
    #1;
    g0 = gotN;
    check(!busy, "R11 idle after clear", busy, 0);
    for (int c = 0; c < 12; c++) @(negedge clk);
    #1;
    check(gotN == g0, "R11 bits after clear", gotN - g0, 0);
    check(doneCnt == d0, "R11 done after clear", doneCnt - d0, 0);
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_defaults();
    t_tail();
    t_newTaps();
    t_busyWrite();
    t_stall();
    t_abort();
    // R4: clean burst after an abort starts from a cleared history
    for (int i = 0; i < 4; i++) dataV[i] = 1'b1;
    runData(4, 1'b0, "R4 after abort");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule